// File: doc/BRIEF.md
# Audio Sample Buffer Pair with Threshold DMA Requests

This block sits between a host (processor or DMA engine) and the serializer of a serial PCM audio port. It holds two independent 32-entry queues of 16-bit samples. The playback queue is filled by host writes and drained by the serializer. The capture queue is filled by the serializer and drained by host reads. Each queue reports its occupancy and four level flags. Each queue raises a DMA request from a programmable 6-bit threshold: playback asks for data while it is running low, and capture asks to be emptied while it is filling up.

Twelve sticky status bits record level conditions and error events for both directions. Errors are an underrun (a pop from an empty queue) and an overrun (a push into a full queue). Software clears the status bits through a write-one-to-clear vector. A single interrupt line combines the status bits that are set and not masked, and a global enable gates that line. When a direction's queue enable is low, that queue is flushed and held idle.

Status vector layout, six bits per direction, playback at 0..5 and capture at 6..11: +0 empty, +1 almost empty, +2 full, +3 almost full, +4 underrun, +5 overrun. The level-flag outputs use the same order in their bits 0..3.

Top module: `pcm_sample_buffer`

## Requirements
- R1: After reset both counts are 0, `tx_level` and `rx_level` read 4'b0011, and the status vector, `irq`, both DMA requests and `host_rdata` are all 0.
- R2: Each queue holds up to 32 samples and returns them in the order written. Its count goes up by one on each accepted push and down by one on each accepted pop.
- R3: Level flag bit 0 is count==0, bit 1 is count<=4, bit 2 is count==32 and bit 3 is count>=28.
- R4: `tx_dma_req` is 1 exactly when `tx_en`, `tx_dma_en` and `tx_count <= tx_thresh` all hold.
- R5: `rx_dma_req` is 1 exactly when `rx_en`, `rx_dma_en` and `rx_count >= rx_thresh` all hold.
- R6: `host_rdata[16]` is 1 when the capture queue is not empty, and bits 15:0 then carry its oldest sample. When the queue is empty the whole word is 0.
- R7: A serializer pop of an empty playback queue presents 0 on `ser_tx_data`, leaves the count at 0 and sets status bit 4.
- R8: A serializer push into a full capture queue drops the sample, keeps the count at 32 and the stored samples unchanged, and sets status bit 11.
- R9: A host write to a full playback queue is dropped and sets status bit 5. A host read of an empty capture queue sets status bit 10.
- R10: Status bits are set at the clock edge that follows a level condition, or at the edge of an error event. They stay set until the matching `flag_clr` bit is 1 at an edge. A condition still present at that edge keeps its bit set.
- R11: `irq` equals `irq_en` AND the OR of (status AND `irq_mask`).
- R12: When a direction's enable is 0, its queue is emptied at the next edge. Its pushes and pops are ignored, its DMA request is 0 and none of its six status bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Playback queue enable |
| rx_en | input | 1 | Capture queue enable |
| tx_dma_en | input | 1 | Playback DMA request enable |
| rx_dma_en | input | 1 | Capture DMA request enable |
| tx_thresh | input | 6 | Playback DMA threshold |
| rx_thresh | input | 6 | Capture DMA threshold |
| irq_en | input | 1 | Global interrupt enable |
| irq_mask | input | 12 | Per-status-bit interrupt enables |
| flag_clr | input | 12 | Write-one-to-clear pulses for status bits |
| host_wr | input | 1 | Host write strobe into the playback queue |
| host_wdata | input | 16 | Host write sample |
| host_rd | input | 1 | Host read strobe from the capture queue |
| host_rdata | output | 17 | Valid flag (bit 16) and oldest capture sample |
| ser_pop | input | 1 | Serializer takes a playback sample |
| ser_tx_data | output | 16 | Oldest playback sample, 0 when empty |
| ser_push | input | 1 | Serializer delivers a capture sample |
| ser_rx_data | input | 16 | Capture sample from the serializer |
| tx_count | output | 6 | Playback queue occupancy |
| rx_count | output | 6 | Capture queue occupancy |
| tx_level | output | 4 | Playback level flags |
| rx_level | output | 4 | Capture level flags |
| tx_dma_req | output | 1 | Playback DMA request |
| rx_dma_req | output | 1 | Capture DMA request |
| status | output | 12 | Sticky status bits |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach are the two error edges. The capture overrun needs a queue holding exactly 32 samples followed by one more push. The playback underrun needs a fully drained queue followed by a pop. The stimulus fills each queue to the brim while checking the count and the DMA request at every step. It then pushes a distinct marker sample and drains the queue in order, which shows that the marker never entered. The sticky-versus-live behaviour of the status bits is reached by clearing every bit while some level conditions still hold, so that only those bits return.

// File: rtl/pcm_buf_pkg.sv
package pcm_buf_pkg;

  // Bit slots inside one direction's six-bit status group
  localparam int SLOT_EMPTY  = 0;
  localparam int SLOT_AEMPTY = 1;
  localparam int SLOT_FULL   = 2;
  localparam int SLOT_AFULL  = 3;
  localparam int SLOT_UNDER  = 4;
  localparam int SLOT_OVER   = 5;
  localparam int SLOTS_PER_DIR = 6;

  // Level flags in slot order: empty, almost empty, full, almost full
  function automatic logic [3:0] level_flags(input int unsigned cnt,
                                             input int unsigned depth,
                                             input int unsigned ae_lvl,
                                             input int unsigned af_lvl);
    logic [3:0] f;
    f[SLOT_EMPTY]  = (cnt == 0);
    f[SLOT_AEMPTY] = (cnt <= ae_lvl);
    f[SLOT_FULL]   = (cnt == depth);
    f[SLOT_AFULL]  = (cnt >= af_lvl);
    return f;
  endfunction

  // Playback wants data while at or below its threshold
  function automatic logic drain_side_wants(input int unsigned cnt, input int unsigned thr);
    return cnt <= thr;
  endfunction

  // Capture wants service while at or above its threshold
  function automatic logic fill_side_wants(input int unsigned cnt, input int unsigned thr);
    return cnt >= thr;
  endfunction

endpackage

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             push_drop,
  output logic             pop_starve
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             is_empty, is_full, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign is_empty   = (cnt_q == '0);
  assign is_full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok    = enable && push && !is_full;
  assign pop_ok     = enable && pop && !is_empty;
  assign push_drop  = enable && push && is_full;
  assign pop_starve = enable && pop && is_empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  // R2: a lone accepted push grows the count by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> count == $past(count) + CNT_W'(1));

  // R8: a dropped push leaves the occupancy alone
  a_r8_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok) |=> count == $past(count));

  // R12: a disabled queue is empty at the next edge
  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);

endmodule

// File: rtl/pcm_event_status.sv
module pcm_event_status #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  input  logic         glb_en,
  output logic [N-1:0] status,
  output logic         irq
);

  logic [N-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_vec) | set_vec;
  end

  assign status = stat_q;
  assign irq    = glb_en && |(stat_q & mask);

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R10: a set bit stays set unless cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr_vec[i]) |=> status[i]);
    // R10: a present condition wins over a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status[i]);
  end

  // R11: no interrupt without the global enable
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_en);

endmodule

// File: rtl/pcm_sample_buffer.sv
module pcm_sample_buffer
  import pcm_buf_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  parameter int AE_LVL = 4,
  parameter int AF_LVL = 28,
  parameter int THR_W  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NST   = 2 * SLOTS_PER_DIR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [THR_W-1:0] tx_thresh,
  input  logic [THR_W-1:0] rx_thresh,
  input  logic             irq_en,
  input  logic [NST-1:0]   irq_mask,
  input  logic [NST-1:0]   flag_clr,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW:0]      host_rdata,
  input  logic             ser_pop,
  output logic [DW-1:0]    ser_tx_data,
  input  logic             ser_push,
  input  logic [DW-1:0]    ser_rx_data,
  output logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] rx_count,
  output logic [3:0]       tx_level,
  output logic [3:0]       rx_level,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic [NST-1:0]   status,
  output logic             irq
);

  localparam int TX_BASE = 0;
  localparam int RX_BASE = SLOTS_PER_DIR;

  logic [DW-1:0] tx_head, rx_head;
  logic          tx_over_evt, tx_under_evt, rx_over_evt, rx_under_evt;
  logic [NST-1:0] set_vec;

  pcm_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .enable(tx_en),
    .push(host_wr), .push_data(host_wdata), .pop(ser_pop),
    .head(tx_head), .count(tx_count),
    .push_drop(tx_over_evt), .pop_starve(tx_under_evt));

  pcm_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .enable(rx_en),
    .push(ser_push), .push_data(ser_rx_data), .pop(host_rd),
    .head(rx_head), .count(rx_count),
    .push_drop(rx_over_evt), .pop_starve(rx_under_evt));

  assign tx_level = level_flags(32'(tx_count), DEPTH, AE_LVL, AF_LVL);
  assign rx_level = level_flags(32'(rx_count), DEPTH, AE_LVL, AF_LVL);

  assign tx_dma_req = tx_en && tx_dma_en && drain_side_wants(32'(tx_count), 32'(tx_thresh));
  assign rx_dma_req = rx_en && rx_dma_en && fill_side_wants(32'(rx_count), 32'(rx_thresh));

  assign ser_tx_data = tx_level[SLOT_EMPTY] ? '0 : tx_head;
  assign host_rdata  = rx_level[SLOT_EMPTY] ? '0 : {1'b1, rx_head};

  // Status group per direction, gated by that direction's enable
  always_comb begin
    set_vec = '0;
    if (tx_en) begin
      set_vec[TX_BASE + SLOT_EMPTY]  = tx_level[SLOT_EMPTY];
      set_vec[TX_BASE + SLOT_AEMPTY] = tx_level[SLOT_AEMPTY];
      set_vec[TX_BASE + SLOT_FULL]   = tx_level[SLOT_FULL];
      set_vec[TX_BASE + SLOT_AFULL]  = tx_level[SLOT_AFULL];
      set_vec[TX_BASE + SLOT_UNDER]  = tx_under_evt;
      set_vec[TX_BASE + SLOT_OVER]   = tx_over_evt;
    end
    if (rx_en) begin
      set_vec[RX_BASE + SLOT_EMPTY]  = rx_level[SLOT_EMPTY];
      set_vec[RX_BASE + SLOT_AEMPTY] = rx_level[SLOT_AEMPTY];
      set_vec[RX_BASE + SLOT_FULL]   = rx_level[SLOT_FULL];
      set_vec[RX_BASE + SLOT_AFULL]  = rx_level[SLOT_AFULL];
      set_vec[RX_BASE + SLOT_UNDER]  = rx_under_evt;
      set_vec[RX_BASE + SLOT_OVER]   = rx_over_evt;
    end
  end

  pcm_event_status #(.N(NST)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(flag_clr),
    .mask(irq_mask), .glb_en(irq_en), .status(status), .irq(irq));

  // R4: playback request only at or below its threshold
  a_r4_tx_req_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> 32'(tx_count) <= 32'(tx_thresh));

  // R5: capture request only at or above its threshold
  a_r5_rx_req_level: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> 32'(rx_count) >= 32'(rx_thresh));

  // R6: a valid read word implies a non-empty capture queue
  a_r6_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DW] |-> rx_count != '0);

  // R7: an underrun pop sends silence and flags it
  a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ser_pop && tx_count == '0) |-> ser_tx_data == '0 ##1 status[TX_BASE + SLOT_UNDER]);

  // R8: an overrun push keeps the queue full and flags it
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ser_push && !host_rd && rx_count == CNT_W'(DEPTH)) |=>
      (rx_count == CNT_W'(DEPTH) && status[RX_BASE + SLOT_OVER]));

  // R12: a disabled direction never requests DMA
  a_r12_no_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en |-> !tx_dma_req) and (!rx_en |-> !rx_dma_req));

endmodule

// File: tb/sim_pcm_sample_buffer.sv
module sim_pcm_sample_buffer;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en, rx_en, tx_dma_en, rx_dma_en, irq_en;
  logic [5:0] tx_thresh, rx_thresh;
  logic [11:0] irq_mask, flag_clr;
  logic host_wr, host_rd, ser_pop, ser_push;
  logic [15:0] host_wdata, ser_rx_data, ser_tx_data;
  logic [16:0] host_rdata;
  logic [5:0] tx_count, rx_count;
  logic [3:0] tx_level, rx_level;
  logic tx_dma_req, rx_dma_req, irq;
  logic [11:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcm_sample_buffer u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .irq_en(irq_en), .irq_mask(irq_mask), .flag_clr(flag_clr),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .ser_pop(ser_pop), .ser_tx_data(ser_tx_data),
    .ser_push(ser_push), .ser_rx_data(ser_rx_data),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .status(status), .irq(irq));

  function automatic logic [15:0] tx_pat(input int i);
    return 16'hA000 ^ 16'(i * 291);
  endfunction

  function automatic logic [15:0] rx_pat(input int i);
    return 16'h5A00 + 16'(i * 7);
  endfunction

  // Expected level flags written from R3 independently
  function automatic logic [3:0] exp_lvl(input int c);
    logic [3:0] f;
    f = 4'b0000;
    if (c == 0)  f = f | 4'b0001;
    if (c <= 4)  f = f | 4'b0010;
    if (c == 32) f = f | 4'b0100;
    if (c >= 28) f = f | 4'b1000;
    return f;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "tx_count", 32'(tx_count), 0);
    chk("R1", "rx_count", 32'(rx_count), 0);
    chk("R1", "tx_level", 32'(tx_level), 32'h3);
    chk("R1", "rx_level", 32'(rx_level), 32'h3);
    chk("R1", "status", 32'(status), 0);
    chk("R1", "irq/dma", {29'd0, irq, tx_dma_req, rx_dma_req}, 0);
    chk("R1", "host_rdata", 32'(host_rdata), 0);
  endtask

  task automatic t_playback();
    tx_en = 1; tx_dma_en = 1; tx_thresh = 6'd4;
    step();
    chk("R4", "tx_dma_req at 0", 32'(tx_dma_req), 1);
    for (int i = 0; i < 32; i++) begin
      host_wr = 1; host_wdata = tx_pat(i);
      step();
      chk("R2", "tx_count fill", 32'(tx_count), 32'(i + 1));
      chk("R4", "tx_dma_req fill", 32'(tx_dma_req), 32'((i + 1) <= 4));
      if (i + 1 == 4 || i + 1 == 5 || i + 1 == 28 || i + 1 == 27 || i + 1 == 32)
        chk("R3", "tx_level", 32'(tx_level), 32'(exp_lvl(i + 1)));
    end
    host_wdata = 16'hDEAD;
    step();
    host_wr = 0;
    chk("R9", "tx overrun bit5", 32'(status[5]), 1);
    chk("R9", "tx count stays full", 32'(tx_count), 32);
    step();
    chk("R3", "tx full status bit2", 32'(status[2]), 1);
    for (int i = 0; i < 32; i++) begin
      chk("R2", "ser_tx_data order", 32'(ser_tx_data), 32'(tx_pat(i)));
      ser_pop = 1;
      step();
    end
    ser_pop = 0;
    chk("R2", "tx drained", 32'(tx_count), 0);
    chk("R7", "silence when empty", 32'(ser_tx_data), 0);
    ser_pop = 1;
    step();
    ser_pop = 0;
    chk("R7", "underrun count", 32'(tx_count), 0);
    chk("R7", "underrun bit4", 32'(status[4]), 1);
  endtask

  task automatic t_capture();
    rx_en = 1; rx_dma_en = 1; rx_thresh = 6'd32;
    step();
    chk("R6", "empty read word", 32'(host_rdata), 0);
    for (int i = 0; i < 32; i++) begin
      ser_push = 1; ser_rx_data = rx_pat(i);
      step();
      chk("R5", "rx_dma_req fill", 32'(rx_dma_req), 32'((i + 1) >= 32));
    end
    chk("R3", "rx_level full", 32'(rx_level), 32'(exp_lvl(32)));
    ser_rx_data = 16'hBEEF;
    step();
    ser_push = 0;
    chk("R8", "rx overrun bit11", 32'(status[11]), 1);
    chk("R8", "rx count stays full", 32'(rx_count), 32);
    for (int i = 0; i < 32; i++) begin
      chk("R6", "host_rdata order", 32'(host_rdata), {15'd0, 1'b1, rx_pat(i)});
      host_rd = 1;
      step();
    end
    host_rd = 0;
    chk("R8", "marker never stored", 32'(host_rdata), 0);
    host_rd = 1;
    step();
    host_rd = 0;
    chk("R9", "rx underrun bit10", 32'(status[10]), 1);
    chk("R5", "rx_dma_req empty", 32'(rx_dma_req), 0);
  endtask

  task automatic t_status_irq();
    chk("R10", "full bit sticky after drain", 32'(status[2]), 1);
    flag_clr = 12'hFFF;
    step();
    flag_clr = 12'h000;
    chk("R10", "only live levels survive", 32'(status), 32'h0C3);
    irq_mask = 12'h010; irq_en = 1;
    step();
    chk("R11", "irq masked status clear", 32'(irq), 0);
    ser_pop = 1;
    step();
    ser_pop = 0;
    chk("R11", "irq on underrun", 32'(irq), 1);
    irq_en = 0;
    step();
    chk("R11", "irq global off", 32'(irq), 0);
    irq_en = 1; irq_mask = 12'h020;
    step();
    chk("R11", "irq other bit masked", 32'(irq), 0);
  endtask

  task automatic t_disable();
    for (int i = 0; i < 3; i++) begin
      host_wr = 1; host_wdata = tx_pat(i + 40);
      step();
    end
    host_wr = 0;
    chk("R2", "three queued", 32'(tx_count), 3);
    tx_en = 0;
    step();
    chk("R12", "flushed", 32'(tx_count), 0);
    chk("R12", "no dma when off", 32'(tx_dma_req), 0);
    flag_clr = 12'h03F;
    step();
    flag_clr = 12'h000;
    host_wr = 1; host_wdata = 16'h1234; ser_pop = 1;
    step();
    host_wr = 0; ser_pop = 0;
    step();
    chk("R12", "write ignored", 32'(tx_count), 0);
    chk("R12", "no tx status", 32'(status[5:0]), 0);
    tx_en = 1;
    step();
    chk("R12", "reenabled empty output", 32'(ser_tx_data), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_en = 0; rx_en = 0; tx_dma_en = 0; rx_dma_en = 0;
    tx_thresh = '0; rx_thresh = '0; irq_en = 0; irq_mask = '0; flag_clr = '0;
    host_wr = 0; host_rd = 0; ser_pop = 0; ser_push = 0;
    host_wdata = '0; ser_rx_data = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_playback();
    t_capture();
    t_status_irq();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule